// File: doc/BRIEF.md
# Programmable Asynchronous Line Receiver

This block receives characters from one asynchronous serial line. A packed 16-bit configuration word sets its character length, stop-bit count, parity mode, speed and receiver enable. Each word carries a two-bit line address, and the block accepts a word only when that address matches its own `LINE_ID` parameter. Four copies of the block can therefore share one configuration bus.

A divisor derived from the fixed reference clock `CLK_HZ` sets the sampling rate to sixteen times the selected baud rate. The block confirms the start bit at mid-bit and assembles 5 to 8 data bits, least significant bit first. It then checks parity and the first stop bit. Each completed character leaves on a valid/ready stream together with its parity-error and framing-error flags.

The output stage holds one character. `out_valid` stays high, and the character and flags stay constant, until the consumer asserts `out_ready`. If a new character completes while the held one has not been accepted, the new character is discarded. A character that completes in the same cycle as the handshake replaces the held one.

Top module: `line_rx`

## Requirements
- R1: A configuration write (`cfg_we` high for one clock) takes effect only when word bits 1:0 equal `LINE_ID`. A write with any other address leaves the active settings unchanged.
- R2: Word bits 4:3 set the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits arrive LSB first. The character is delivered right-aligned, with its unused upper bits set to zero.
- R3: Word bit 6 enables a parity bit after the data, and bit 7 selects odd parity (1) or even parity (0). `out_perr` is set when the data bits and the parity bit together do not have the selected parity. `out_perr` is never set while parity is disabled.
- R4: Word bits 11:8 select the speed: codes 0 to 15 give 50, 75, 110, 134.5, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200, 9600 and 19200 baud. The line is sampled at 16 times the rate. The divisor is `CLK_HZ / (16 * rate)`, rounded to the nearest integer and at least 1.
- R5: Word bit 12 enables the receiver. While it is clear, no character is produced. Clearing it in the middle of a frame abandons that frame.
- R6: A falling edge starts a frame only if the line is still low at the mid-bit sample, 8 sample ticks later. Otherwise the receiver returns to idle and produces nothing.
- R7: `out_ferr` is set when the first stop bit is sampled low; this is how a break shows up. After a framing error the receiver waits for the line to return high before it looks for a new start bit, so a long break yields exactly one character.
- R8: Word bit 5 selects two stop bits (1) or one stop bit (0). With two stop bits, only the first is checked, and the receiver ignores the line until the second stop bit has ended.
- R9: `out_valid`, `out_char`, `out_perr` and `out_ferr` hold steady until `out_ready` is high. A character completed while the held one is still waiting is discarded.
- R10: Word bits 15:13 and bit 2 have no effect on the receiver's behaviour.
- R11: After reset, `out_valid` is low and the receiver is disabled, with all configuration fields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at `CLK_HZ` |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word strobe |
| cfg_word | input | 16 | Packed line configuration word |
| rxd | input | 1 | Asynchronous serial line, idle high |
| out_valid | output | 1 | Received character available |
| out_ready | input | 1 | Consumer accepts the character |
| out_char | output | 8 | Received character, right-aligned |
| out_perr | output | 1 | Parity error flag for `out_char` |
| out_ferr | output | 1 | Framing error (break) flag for `out_char` |

## Verification
The bench builds the block with `CLK_HZ = 307200` and `LINE_ID = 2`. With that clock, the 19200-baud code divides down to one cycle per sample tick, so most frames last only a few hundred cycles. At the same clock, the 134.5-baud code still gives a divisor of 143, and the 7200-baud code gives a rounded divisor of 3, so the non-integer rates and the rounding can be checked within the cycle budget. Setting `LINE_ID` to 2 makes a write addressed to line 1 a real mismatch, which exercises the address decode.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_STOP2,
    ST_HOLD
  } lrx_state_t;

  typedef struct packed {
    logic       rx_en;
    logic [3:0] speed;
    logic       odd;
    logic       par_en;
    logic       two_stop;
    logic [1:0] len;
  } lrx_cfg_t;

  // Twice the baud rate for each speed code (keeps 134.5 integral).
  function automatic int unsigned lrx_rate2(input logic [3:0] code);
    int unsigned r;
    case (code)
      4'd0:  r = 100;
      4'd1:  r = 150;
      4'd2:  r = 220;
      4'd3:  r = 269;
      4'd4:  r = 300;
      4'd5:  r = 600;
      4'd6:  r = 1200;
      4'd7:  r = 2400;
      4'd8:  r = 3600;
      4'd9:  r = 4000;
      4'd10: r = 4800;
      4'd11: r = 7200;
      4'd12: r = 9600;
      4'd13: r = 14400;
      4'd14: r = 19200;
      default: r = 38400;
    endcase
    return r;
  endfunction

  // Rounded clock divisor for a 16x sample tick.
  function automatic int unsigned lrx_div(input int unsigned clk_hz,
                                          input logic [3:0] code);
    longint unsigned num;
    longint unsigned den;
    longint unsigned q;
    num = longint'(clk_hz) * 64'd4;
    den = 64'd16 * longint'(lrx_rate2(code));
    q   = ((num / den) + 64'd1) / 64'd2;
    if (q == 64'd0) q = 64'd1;
    return int'(q);
  endfunction

endpackage

// File: rtl/lrx_cfg_reg.sv
module lrx_cfg_reg
  import lrx_pkg::*;
#(
  parameter int unsigned LINE_ID = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] word,
  output lrx_cfg_t    cfg
);
  localparam logic [1:0] ADDR = 2'(LINE_ID);

  logic rsv_unused;
  assign rsv_unused = ^{word[15:13], word[2]};

  logic hit;
  assign hit = we && (word[1:0] == ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (hit) begin
      cfg.rx_en    <= word[12];
      cfg.speed    <= word[11:8];
      cfg.odd      <= word[7];
      cfg.par_en   <= word[6];
      cfg.two_stop <= word[5];
      cfg.len      <= word[4:3];
    end
  end
endmodule

// File: rtl/lrx_baud_gen.sv
module lrx_baud_gen
  import lrx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned DIV_W  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] speed,
  input  logic       restart,
  output logic       tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_m1;

  always_comb begin
    div_m1 = DIV_W'(lrx_div(CLK_HZ, speed) - 1);
  end

  assign tick = (cnt == div_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lrx_frame.sv
module lrx_frame
  import lrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       tick,
  input  logic       rx_en,
  input  logic [1:0] len,
  input  logic       par_en,
  input  logic       odd,
  input  logic       two_stop,
  output logic       restart,
  output logic       done,
  output logic [7:0] char_o,
  output logic       perr_o,
  output logic       ferr_o
);
  localparam int unsigned SYNC_N = 2;
  localparam logic [4:0] MID_T  = 5'd7;
  localparam logic [4:0] BIT_T  = 5'd15;
  localparam logic [4:0] TAIL_T = 5'd23;

  logic [SYNC_N-1:0] sync_q;
  logic              line;
  lrx_state_t        state;
  logic [4:0]        cnt;
  logic [2:0]        bitn;
  logic [7:0]        sh;
  logic              pbit;
  logic [7:0]        aligned;
  logic [2:0]        last_bit;

  assign line     = sync_q[SYNC_N-1];
  assign restart  = (state == ST_IDLE) && rx_en && !line;
  assign aligned  = sh >> (2'd3 - len);
  assign last_bit = {1'b1, len};

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_N-2:0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      pbit   <= 1'b0;
      done   <= 1'b0;
      char_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!rx_en) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (restart) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (tick) begin
              if (cnt == MID_T) begin
                cnt  <= '0;
                bitn <= '0;
                sh   <= '0;
                state <= line ? ST_IDLE : ST_DATA;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_DATA: begin
            if (tick) begin
              if (cnt == BIT_T) begin
                cnt  <= '0;
                sh   <= {line, sh[7:1]};
                bitn <= bitn + 1'b1;
                if (bitn == last_bit) state <= par_en ? ST_PAR : ST_STOP;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_PAR: begin
            if (tick) begin
              if (cnt == BIT_T) begin
                cnt   <= '0;
                pbit  <= line;
                state <= ST_STOP;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_STOP: begin
            if (tick) begin
              if (cnt == BIT_T) begin
                cnt    <= '0;
                done   <= 1'b1;
                char_o <= aligned;
                perr_o <= par_en && ((^aligned) ^ pbit ^ odd);
                ferr_o <= !line;
                if (!line)         state <= ST_HOLD;
                else if (two_stop) state <= ST_STOP2;
                else               state <= ST_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_STOP2: begin
            if (tick) begin
              if (cnt == TAIL_T) begin
                cnt   <= '0;
                state <= ST_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_HOLD: begin
            if (line) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lrx_out_stage.sv
module lrx_out_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  logic [7:0] char_i,
  input  logic       perr_i,
  input  logic       ferr_i,
  input  logic       ready,
  output logic       valid,
  output logic [7:0] char_o,
  output logic       perr_o,
  output logic       ferr_o
);
  logic load;
  assign load = done && (!valid || ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      char_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else if (load) begin
      valid  <= 1'b1;
      char_o <= char_i;
      perr_o <= perr_i;
      ferr_o <= ferr_i;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/line_rx.sv
module line_rx
  import lrx_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned LINE_ID = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_word,
  input  logic        rxd,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_char,
  output logic        out_perr,
  output logic        out_ferr
);
  localparam int unsigned MAX_DIV = lrx_div(CLK_HZ, 4'd0);
  localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);

  lrx_cfg_t   cfg_q;
  logic       tick;
  logic       restart;
  logic       frm_done;
  logic [7:0] frm_char;
  logic       frm_perr;
  logic       frm_ferr;

  lrx_cfg_reg #(.LINE_ID(LINE_ID)) u_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .word (cfg_word),
    .cfg  (cfg_q)
  );

  lrx_baud_gen #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .speed  (cfg_q.speed),
    .restart(restart),
    .tick   (tick)
  );

  lrx_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .rxd     (rxd),
    .tick    (tick),
    .rx_en   (cfg_q.rx_en),
    .len     (cfg_q.len),
    .par_en  (cfg_q.par_en),
    .odd     (cfg_q.odd),
    .two_stop(cfg_q.two_stop),
    .restart (restart),
    .done    (frm_done),
    .char_o  (frm_char),
    .perr_o  (frm_perr),
    .ferr_o  (frm_ferr)
  );

  lrx_out_stage u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (frm_done),
    .char_i(frm_char),
    .perr_i(frm_perr),
    .ferr_i(frm_ferr),
    .ready (out_ready),
    .valid (out_valid),
    .char_o(out_char),
    .perr_o(out_perr),
    .ferr_o(out_ferr)
  );
endmodule

// File: rtl/lrx_checker.sv
module lrx_checker
  import lrx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_char,
  input logic       out_perr,
  input logic       out_ferr,
  input logic       frm_done,
  input logic       frm_perr,
  input lrx_cfg_t   cfg_q
);
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_char)
                                   && $stable(out_perr) && $stable(out_ferr)));

  assert_drop_after_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  assert_rise_from_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frm_done));

  assert_done_when_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> $past(cfg_q.rx_en));

  assert_cfg_only_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(cfg_we));

  assert_perr_needs_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && frm_perr) |-> $past(cfg_q.par_en));
endmodule

bind line_rx lrx_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_char (out_char),
  .out_perr (out_perr),
  .out_ferr (out_ferr),
  .frm_done (frm_done),
  .frm_perr (frm_perr),
  .cfg_q    (cfg_q)
);

// File: tb/line_rx_bench.sv
module line_rx_bench;
  localparam int unsigned CLK_HZ = 307200;
  localparam int unsigned LINE   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        rxd = 1'b1;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [7:0]  out_char;
  logic        out_perr;
  logic        out_ferr;

  always #10 clk = ~clk;

  line_rx #(.CLK_HZ(CLK_HZ), .LINE_ID(LINE)) u_line_rx (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word), .rxd(rxd),
    .out_valid(out_valid), .out_ready(out_ready), .out_char(out_char),
    .out_perr(out_perr), .out_ferr(out_ferr)
  );

  typedef struct {
    logic [7:0] ch;
    logic       pe;
    logic       fe;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit ended  = 0;

  int bitcyc = 16;
  int b_len  = 8;
  bit b_par  = 0;
  bit b_odd  = 0;
  bit b_two  = 0;

  function automatic int rate_div(input int code);
    real r;
    case (code)
      0: r = 50.0;     1: r = 75.0;     2: r = 110.0;    3: r = 134.5;
      4: r = 150.0;    5: r = 300.0;    6: r = 600.0;    7: r = 1200.0;
      8: r = 1800.0;   9: r = 2000.0;   10: r = 2400.0;  11: r = 3600.0;
      12: r = 4800.0;  13: r = 7200.0;  14: r = 9600.0;  default: r = 19200.0;
    endcase
    rate_div = $rtoi(real'(CLK_HZ) / (16.0 * r) + 0.5);
    if (rate_div < 1) rate_div = 1;
  endfunction

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Monitor: pops one expected item for each handshake.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected (R5/R6/R7/R9): actual %0h pe%0d fe%0d expected none",
                 out_char, out_perr, out_ferr);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (out_char !== e.ch || out_perr !== e.pe || out_ferr !== e.fe) begin
          n_fail++;
          $display("FAIL %s: actual %0h pe%0d fe%0d expected %0h pe%0d fe%0d",
                   e.tag, out_char, out_perr, out_ferr, e.ch, e.pe, e.fe);
        end
      end
    end
  end

  task automatic expect_item(input logic [7:0] ch, input bit pe, input bit fe, input string tag);
    item_t e;
    e.ch = ch; e.pe = pe; e.fe = fe; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wcfg(input int line, input bit en, input int speed, input bit odd,
                      input bit par, input bit two, input int len_bits, input bit rsv);
    logic [15:0] w;
    w = '0;
    w[1:0]  = 2'(line);
    w[4:3]  = 2'(len_bits - 5);
    w[5]    = two;
    w[6]    = par;
    w[7]    = odd;
    w[11:8] = 4'(speed);
    w[12]   = en;
    if (rsv) begin
      w[15:13] = 3'b111;
      w[2]     = 1'b1;
    end
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_word = w;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_word = '0;
    if (line == LINE) begin
      bitcyc = 16 * rate_div(speed);
      b_len = len_bits; b_par = par; b_odd = odd; b_two = two;
    end
  endtask

  task automatic line_bit(input logic v);
    @(posedge clk); #1;
    rxd = v;
    repeat (bitcyc - 1) @(posedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit flip_par,
                      input logic stop_v, input logic stop2_v);
    logic [7:0] m;
    m = d & 8'((1 << b_len) - 1);
    line_bit(1'b0);
    for (int i = 0; i < b_len; i++) line_bit(d[i]);
    if (b_par) line_bit((^m) ^ b_odd ^ flip_par);
    line_bit(stop_v);
    if (b_two) line_bit(stop2_v);
    line_bit(1'b1);
  endtask

  task automatic settle();
    repeat (40) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R11 reset valid", out_valid, 0);

    // R11: receiver disabled after reset, nothing comes out
    send(8'h5A, 0, 1'b1, 1'b1);
    settle();
    check(out_valid === 1'b0, "R11 disabled after reset", out_valid, 0);

    // R4/R2: 8N1 at code 15
    wcfg(LINE, 1, 15, 0, 0, 0, 8, 0);
    expect_item(8'hA5, 0, 0, "R2 8bit A5"); send(8'hA5, 0, 1'b1, 1'b1);
    expect_item(8'h3C, 0, 0, "R4 8bit 3C"); send(8'h3C, 0, 1'b1, 1'b1);

    // R2: short characters right-aligned
    wcfg(LINE, 1, 15, 0, 0, 0, 5, 0);
    expect_item(8'h15, 0, 0, "R2 5bit"); send(8'hF5, 0, 1'b1, 1'b1);
    wcfg(LINE, 1, 15, 0, 0, 0, 6, 0);
    expect_item(8'h2B, 0, 0, "R2 6bit"); send(8'hEB, 0, 1'b1, 1'b1);

    // R3: parity even/odd, good and bad
    wcfg(LINE, 1, 15, 0, 1, 0, 7, 0);
    expect_item(8'h55, 0, 0, "R3 even ok");  send(8'h55, 0, 1'b1, 1'b1);
    expect_item(8'h13, 1, 0, "R3 even bad"); send(8'h13, 1, 1'b1, 1'b1);
    wcfg(LINE, 1, 15, 1, 1, 0, 8, 0);
    expect_item(8'hC1, 0, 0, "R3 odd ok");   send(8'hC1, 0, 1'b1, 1'b1);
    expect_item(8'h80, 1, 0, "R3 odd bad");  send(8'h80, 1, 1'b1, 1'b1);

    // R1: write to line 1 ignored; still 8-bit odd parity
    wcfg(1, 1, 0, 0, 0, 0, 5, 0);
    expect_item(8'hF3, 0, 0, "R1 misaddressed"); send(8'hF3, 0, 1'b1, 1'b1);

    // R10: reserved bits set, acts as 7E1
    wcfg(LINE, 1, 15, 0, 1, 0, 7, 1);
    expect_item(8'h6E, 0, 0, "R10 reserved ignored"); send(8'h6E, 0, 1'b1, 1'b1);

    // R6: short glitch rejected, next char fine
    wcfg(LINE, 1, 15, 0, 0, 0, 8, 0);
    @(posedge clk); #1 rxd = 1'b0;
    repeat (4) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (64) @(posedge clk);
    check(out_valid === 1'b0, "R6 glitch", out_valid, 0);
    expect_item(8'h81, 0, 0, "R6 after glitch"); send(8'h81, 0, 1'b1, 1'b1);

    // R7: framing error, and long break gives one char
    expect_item(8'h47, 0, 1, "R7 stop low"); send(8'h47, 0, 1'b0, 1'b1);
    expect_item(8'h00, 0, 1, "R7 break");
    @(posedge clk); #1 rxd = 1'b0;
    repeat (30 * bitcyc) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (2 * bitcyc) @(posedge clk);
    expect_item(8'h99, 0, 0, "R7 after break"); send(8'h99, 0, 1'b1, 1'b1);

    // R8: two stop bits, second low not checked, no spurious start
    wcfg(LINE, 1, 15, 0, 0, 1, 8, 0);
    expect_item(8'h2D, 0, 0, "R8 second stop low"); send(8'h2D, 0, 1'b1, 1'b0);
    expect_item(8'hE0, 0, 0, "R8 next"); send(8'hE0, 0, 1'b1, 1'b1);
    settle();
    check(exp_q.size() == 0, "R8 no extra frame", exp_q.size(), 0);

    // R5: disable mid-frame abandons it; re-enable works
    wcfg(LINE, 1, 15, 0, 0, 0, 8, 0);
    line_bit(1'b0); line_bit(1'b1); line_bit(1'b0);
    wcfg(LINE, 0, 15, 0, 0, 0, 8, 0);
    for (int i = 0; i < 6; i++) line_bit(1'b1);
    line_bit(1'b1); line_bit(1'b1);
    settle();
    check(out_valid === 1'b0, "R5 abandoned", out_valid, 0);
    wcfg(LINE, 1, 15, 0, 0, 0, 8, 0);
    expect_item(8'h42, 0, 0, "R5 re-enabled"); send(8'h42, 0, 1'b1, 1'b1);

    // R9: back-pressure, second char discarded
    @(posedge clk); #1 out_ready = 1'b0;
    expect_item(8'h11, 0, 0, "R9 held char");
    send(8'h11, 0, 1'b1, 1'b1);
    send(8'h22, 0, 1'b1, 1'b1);
    settle();
    @(negedge clk);
    check(out_valid === 1'b1 && out_char === 8'h11, "R9 held value", out_char, 8'h11);
    @(posedge clk); #1 out_ready = 1'b1;
    settle();
    check(out_valid === 1'b0, "R9 drained", out_valid, 0);

    // R4: rounded divisors at 7200 and 134.5 baud
    wcfg(LINE, 1, 13, 0, 0, 0, 8, 0);
    expect_item(8'hB7, 0, 0, "R4 7200"); send(8'hB7, 0, 1'b1, 1'b1);
    wcfg(LINE, 1, 3, 0, 0, 0, 8, 0);
    expect_item(8'h6C, 0, 0, "R4 134.5"); send(8'h6C, 0, 1'b1, 1'b1);
    settle();

    check(exp_q.size() == 0, "R9 all delivered", exp_q.size(), 0);
    summary();
  end
endmodule